// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block conditions two active-low external interrupt inputs for an 8051-style core. Each input passes through a synchronizer. A trigger-type bit chosen by software then decides whether the input raises its request flag on a falling edge or whenever the pin is held low. The flags and the trigger-type bits share one 8-bit control register. The core can rewrite that register as a whole byte or one bit at a time through a bit address.

The interrupt controller sees one request line per input. It returns a one-cycle vector-acknowledge pulse when it enters the matching service routine. In edge mode that pulse clears the flag. In level mode the flag tracks the pin, and neither the acknowledge nor a software write changes it.

Top module: `xint_flag_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and both request lines are low.
- R2: A byte write whose address equals 0x88 loads all eight register bits, and a byte write to any other address changes nothing. A bit write whose bit address is 0x88+n (n = 0..7) loads only bit n, and a bit write outside 0x88..0x8F changes nothing. When both write ports are active in the same cycle, the byte write takes priority.
- R3: Register layout: bit 0 = trigger type of input 0, bit 1 = flag of input 0, bit 2 = trigger type of input 1, bit 3 = flag of input 1. Bits 7..4 are plain storage and read back as written.
- R4: A trigger-type bit of 1 selects falling-edge detection. A 1-to-0 change on the pin, applied before rising edge k, sets the flag after edge k+2 and not earlier.
- R5: In edge mode a vector-acknowledge pulse clears the flag at the next edge. If a falling edge is detected in the same cycle as the acknowledge, the flag stays set.
- R6: A trigger-type bit of 0 selects level detection. The flag equals the inverted pin with the same three-edge latency, and it ignores both the vector acknowledge and software writes to the flag bit.
- R7: In edge mode a software write to a flag bit sets or clears that flag.
- R8: In edge mode a pin held low or a rising edge on the pin does not set the flag again once it has been cleared.
- R9: Request line i equals the flag bit of input i in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_pin_n | input | 2 | Asynchronous active-low interrupt pins |
| byte_wr | input | 1 | Byte write strobe |
| byte_addr | input | 8 | Byte write address |
| byte_data | input | 8 | Byte write data |
| bit_wr | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit write address |
| bit_data | input | 1 | Bit write value |
| vec_ack | input | 2 | One-cycle vector-acknowledge pulse per input |
| ctrl_rdata | output | 8 | Control register read value |
| irq_req | output | 2 | Request line per input |

## Verification
The assertions assume that each vector-acknowledge pulse lasts a single cycle. They also assume that the pins are held high during reset, so the synchronizer leaves reset in its idle state and no false edge appears. The stimulus drives every input on the falling clock edge and always starts with the pins high. It also never activates both write ports in the same cycle, so the byte-over-bit priority is left to the RTL and to review.

// File: rtl/xint_pkg.sv
package xint_pkg;

  // Register bit position of the trigger-type bit for input i
  function automatic int type_pos(input int i);
    return 2 * i;
  endfunction

  // Register bit position of the request flag for input i
  function automatic int flag_pos(input int i);
    return 2 * i + 1;
  endfunction

  // Next flag value. Edge mode: edge beats software write beats acknowledge.
  // Level mode: the flag follows the inverted synchronized pin.
  function automatic logic next_flag(input logic trig_edge, input logic fall_evt,
                                     input logic sync_lvl, input logic sw_wr,
                                     input logic sw_val, input logic ack,
                                     input logic cur);
    logic nxt;
    if (trig_edge) begin
      if (fall_evt)   nxt = 1'b1;
      else if (sw_wr) nxt = sw_val;
      else if (ack)   nxt = 1'b0;
      else            nxt = cur;
    end else begin
      nxt = ~sync_lvl;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_lvl,
  output logic fall_evt
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_n};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sync_lvl = chain_q[STAGES-1];
  assign fall_evt = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/xint_flag_cell.sv
module xint_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_edge,
  input  logic sync_lvl,
  input  logic fall_evt,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic ack,
  output logic flag
);
  import xint_pkg::*;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= next_flag(trig_edge, fall_evt, sync_lvl, sw_wr, sw_val, ack, flag_q);
  end

  assign flag = flag_q;
endmodule

// File: rtl/xint_flag_ctrl.sv
module xint_flag_ctrl #(
  parameter int         NUM_IN      = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REG_ADDR    = 8'h88,
  parameter logic [7:0] BIT_BASE    = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] int_pin_n,
  input  logic              byte_wr,
  input  logic [7:0]        byte_addr,
  input  logic [7:0]        byte_data,
  input  logic              bit_wr,
  input  logic [7:0]        bit_addr,
  input  logic              bit_data,
  input  logic [NUM_IN-1:0] vec_ack,
  output logic [7:0]        ctrl_rdata,
  output logic [NUM_IN-1:0] irq_req
);
  import xint_pkg::*;

  localparam int REG_W = 8;
  localparam int IDX_W = $clog2(REG_W);

  // Named internal events, also observed by the checker
  logic              byte_hit;
  logic              bit_hit;
  logic [REG_W-1:0]  wr_mask;
  logic [REG_W-1:0]  wr_val;
  logic [REG_W-1:0]  store_q;
  logic [REG_W-1:0]  flag_bits;
  logic [NUM_IN-1:0] sync_lvl;
  logic [NUM_IN-1:0] fall_evt;
  logic [NUM_IN-1:0] trig_edge;
  logic [NUM_IN-1:0] flag_wr;
  logic [NUM_IN-1:0] flag_wval;
  logic [NUM_IN-1:0] flag_vec;

  assign byte_hit = byte_wr && (byte_addr == REG_ADDR);
  assign bit_hit  = bit_wr && (bit_addr[REG_W-1:IDX_W] == BIT_BASE[REG_W-1:IDX_W]);

  always_comb begin
    for (int j = 0; j < REG_W; j++) begin
      wr_mask[j] = byte_hit || (bit_hit && (bit_addr[IDX_W-1:0] == IDX_W'(j)));
      wr_val[j]  = byte_hit ? byte_data[j] : bit_data;
    end
  end

  // Plain storage for every non-flag bit; flag positions stay zero here
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
    end else begin
      for (int j = 0; j < REG_W; j++) begin
        if (wr_mask[j] && !((j % 2 == 1) && (j < 2 * NUM_IN)))
          store_q[j] <= wr_val[j];
      end
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign trig_edge[i] = store_q[type_pos(i)];
    assign flag_wr[i]   = wr_mask[flag_pos(i)];
    assign flag_wval[i] = wr_val[flag_pos(i)];

    xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (int_pin_n[i]),
      .sync_lvl (sync_lvl[i]),
      .fall_evt (fall_evt[i])
    );

    xint_flag_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_edge (trig_edge[i]),
      .sync_lvl  (sync_lvl[i]),
      .fall_evt  (fall_evt[i]),
      .sw_wr     (flag_wr[i]),
      .sw_val    (flag_wval[i]),
      .ack       (vec_ack[i]),
      .flag      (flag_vec[i])
    );
  end

  always_comb begin
    flag_bits = '0;
    for (int i = 0; i < NUM_IN; i++) flag_bits[flag_pos(i)] = flag_vec[i];
  end

  assign ctrl_rdata = store_q | flag_bits;
  assign irq_req    = flag_vec;
endmodule

// File: rtl/xint_flag_chk.sv
module xint_flag_chk #(
  parameter int NUM_IN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_wr,
  input logic [7:0]        ctrl_rdata,
  input logic [NUM_IN-1:0] irq_req,
  input logic [NUM_IN-1:0] trig_edge,
  input logic [NUM_IN-1:0] fall_evt,
  input logic [NUM_IN-1:0] sync_lvl,
  input logic [NUM_IN-1:0] flag_wr,
  input logic [NUM_IN-1:0] flag_wval,
  input logic [NUM_IN-1:0] vec_ack
);
  p_upper_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(ctrl_rdata[7:2*NUM_IN]));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge[i] && fall_evt[i]) |=> irq_req[i]);

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge[i] && vec_ack[i] && !fall_evt[i] && !flag_wr[i]) |=> !irq_req[i]);

    p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_edge[i] |=> (irq_req[i] == !$past(sync_lvl[i])));

    p_sw_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge[i] && flag_wr[i] && !fall_evt[i]) |=> (irq_req[i] == $past(flag_wval[i])));

    p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge[i] && !fall_evt[i] && !flag_wr[i] && !vec_ack[i]) |=> $stable(irq_req[i]));

    p_req_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[i] == ctrl_rdata[2*i+1]);
  end
endmodule

bind xint_flag_ctrl xint_flag_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .any_wr     (byte_hit || bit_hit),
  .ctrl_rdata (ctrl_rdata),
  .irq_req    (irq_req),
  .trig_edge  (trig_edge),
  .fall_evt   (fall_evt),
  .sync_lvl   (sync_lvl),
  .flag_wr    (flag_wr),
  .flag_wval  (flag_wval),
  .vec_ack    (vec_ack)
);

// File: tb/xint_flag_ctrl_tb.sv
module xint_flag_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] int_pin_n = 2'b11;
  logic       byte_wr = 1'b0;
  logic [7:0] byte_addr = '0;
  logic [7:0] byte_data = '0;
  logic       bit_wr = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       bit_data = 1'b0;
  logic [1:0] vec_ack = '0;
  logic [7:0] ctrl_rdata;
  logic [1:0] irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  xint_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .int_pin_n(int_pin_n),
    .byte_wr(byte_wr), .byte_addr(byte_addr), .byte_data(byte_data),
    .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_data(bit_data),
    .vec_ack(vec_ack), .ctrl_rdata(ctrl_rdata), .irq_req(irq_req)
  );

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Expected request lines from an expected register value (R9)
  function automatic logic [7:0] req_of(input logic [7:0] r);
    return {6'b0, r[3], r[1]};
  endfunction

  task automatic check_all(input string req, input logic [7:0] exp);
    check(req, ctrl_rdata, exp);
    check({req, "/R9"}, {6'b0, irq_req}, req_of(exp));
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    byte_wr = 1'b1; byte_addr = a; byte_data = d;
    step(1);
    byte_wr = 1'b0;
  endtask

  task automatic wr_bit(input logic [7:0] a, input logic d);
    bit_wr = 1'b1; bit_addr = a; bit_data = d;
    step(1);
    bit_wr = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] old_v;
    logic [7:0] cur;
    @(negedge clk);
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset", 8'h00);

    // R2/R3 byte sweep, pins idle high. Flag holds a written 1 only when
    // both the old and the new trigger type select edge mode.
    old_v = 8'h00;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      logic [7:0] exp;
      vb = 8'(v);
      wr_byte(8'h88, vb);
      step(1);
      exp = vb & 8'hF5;
      exp[1] = old_v[0] & vb[0] & vb[1];
      exp[3] = old_v[2] & vb[2] & vb[3];
      check_all("R2/R3 byte sweep", exp);
      old_v = vb;
    end
    cur = ctrl_rdata;

    wr_byte(8'h89, 8'h00);
    step(1);
    check_all("R2 wrong byte addr", cur);

    // R2 bit sweep from edge-mode base 0x05
    for (int n = 0; n < 8; n++) begin
      wr_byte(8'h88, 8'h05);
      step(1);
      wr_bit(8'h80 + 8'(n), 1'b1);
      step(1);
      check_all("R2 bit outside range", 8'h05);
      wr_bit(8'h88 + 8'(n), 1'b1);
      step(1);
      check_all("R2/R7 bit set", 8'h05 | (8'h01 << n));
      wr_bit(8'h88 + 8'(n), 1'b0);
      step(1);
      check_all("R2/R7 bit clear", 8'h05 & ~(8'h01 << n));
    end

    // Edge mode per input
    for (int i = 0; i < 2; i++) begin
      logic [7:0] fb;
      logic [7:0] base;
      fb = 8'h02 << (2 * i);
      base = 8'h05;
      wr_byte(8'h88, base);
      step(2);
      check_all("R4 idle", base);
      int_pin_n[i] = 1'b0;
      step(2);
      check_all("R4 not yet set", base);
      step(1);
      check_all("R4 edge sets flag", base | fb);
      vec_ack[i] = 1'b1;
      step(1);
      vec_ack[i] = 1'b0;
      check_all("R5 ack clears", base);
      step(5);
      check_all("R8 held low no reset", base);
      int_pin_n[i] = 1'b1;
      step(5);
      check_all("R8 rising edge ignored", base);
      // R5 edge wins over a coincident acknowledge
      wr_bit(8'h89 + 8'(2 * i), 1'b1);
      check_all("R7 sw set", base | fb);
      int_pin_n[i] = 1'b0;
      step(2);
      vec_ack[i] = 1'b1;
      step(1);
      vec_ack[i] = 1'b0;
      check_all("R5 edge beats ack", base | fb);
      wr_bit(8'h89 + 8'(2 * i), 1'b0);
      check_all("R7 sw clear", base);
      int_pin_n[i] = 1'b1;
      step(4);
    end

    // Level mode per input
    for (int i = 0; i < 2; i++) begin
      logic [7:0] fb;
      fb = 8'h02 << (2 * i);
      wr_byte(8'h88, 8'hA0);
      step(2);
      check_all("R6 level idle", 8'hA0);
      int_pin_n[i] = 1'b0;
      step(2);
      check_all("R6 level latency", 8'hA0);
      step(1);
      check_all("R6 level low sets", 8'hA0 | fb);
      vec_ack[i] = 1'b1;
      step(1);
      vec_ack[i] = 1'b0;
      step(1);
      check_all("R6 ack ignored", 8'hA0 | fb);
      wr_bit(8'h89 + 8'(2 * i), 1'b0);
      step(1);
      check_all("R6 sw write ignored", 8'hA0 | fb);
      int_pin_n[i] = 1'b1;
      step(3);
      check_all("R6 level high clears", 8'hA0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule